// File: doc/BRIEF.md
# Multi-Scheme Square-Carrier Modulator

This block turns a serial bit stream, or an 8-bit unsigned message sample, into a signed sample stream. It can produce five kinds of modulation: amplitude modulation, on-off keying, two-phase shift keying, two-tone frequency keying and four-phase shift keying. A 3-bit scheme select chooses the kind. Every carrier is a square wave taken from a free-running divide counter on the system clock, so no sine table is stored.

Data arrives through a request/response exchange. In the cycle where the block raises `bit_req`, the source holds the next bit on `data_in`, and the block captures it at the closing clock edge. The scheme select and the bits for a symbol are captured during the first cycles of a symbol period. They take effect together at the next symbol boundary, so a symbol is never cut short. A symbol therefore reaches the output one symbol period after its bits are captured.

Top module: `sqcar_mod`

## Requirements
- R1: The scheme select is encoded as 0 = amplitude, 1 = on-off, 2 = two-phase, 3 = two-tone, 4 = four-phase. Codes 5 to 7 are idle. An idle symbol outputs 0, and an idle code on `mode` in the first cycle of a period raises no `bit_req`.
- R2: Counting from t = 0, the first cycle after reset release, the reference carrier at cycle t with phase offset d is positive when (t + d) mod (8·CAR_K) < 4·CAR_K and negative otherwise. The alternate carrier uses 8·ALT_K the same way with d = 0. Every keyed scheme outputs +127, -127 or 0.
- R3: In on-off keying, bit 1 outputs the reference carrier at ±127 and bit 0 outputs 0.
- R4: In two-phase keying, bit 1 uses offset 0 and bit 0 uses offset 4·CAR_K (180°), both at ±127.
- R5: In two-tone keying, bit 1 outputs the reference carrier and bit 0 outputs the alternate carrier, both at ±127.
- R6: In four-phase keying, the first captured bit is the high bit of the pair. The offset is CAR_K for 00, 3·CAR_K for 01, 5·CAR_K for 11 and 7·CAR_K for 10 (+45°, +135°, -135°, -45°), at ±127.
- R7: In amplitude mode the output is +msg while the reference carrier (offset 0) is positive and -msg while it is negative, with `msg` read live. Data bits have no effect.
- R8: A symbol period lasts 2·BIT_LEN clocks for a four-phase symbol and BIT_LEN clocks for every other symbol, including the idle period right after reset.
- R9: `bit_req` is high in the first cycle of a period when `mode` holds a code from 1 to 4. It is also high in the second cycle when the code captured in the first cycle was 4. In every other cycle it is low. `data_in` is captured at the edge that ends a requesting cycle.
- R10: The scheme and bits captured in a period are output during the whole next period. Changes on `mode` or `data_in` after capture have no effect on that symbol.
- R11: While reset is held, `sample` and `bit_req` are 0. After release, `sample` stays 0 for cycles 0 to BIT_LEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Scheme select, captured at the start of a period |
| data_in | input | 1 | Serial data bit, valid while bit_req is high |
| msg | input | 8 | Unsigned message sample for amplitude mode |
| bit_req | output | 1 | Request for the next data bit |
| sample | output | 9 | Signed output sample |

## Verification
`bit_req` and `sample` are combinational functions of the registered state and of `mode`/`msg`. They are therefore due in the same cycle as the state they reflect. A captured symbol appears exactly one period after its capture, at a boundary whose cycle the bench computes from the period lengths. The bench drives inputs on the falling edge, waits one time unit and samples both outputs in that cycle. It keeps its own cycle index t from reset release, so every expected carrier polarity comes from t and the rules in R2 to R7. Late changes of scheme and data, placed after capture in every period, check that the applied symbol follows R10.

// File: rtl/sqcar_mod.sv
module sqcar_mod #(
  parameter int CAR_K   = 2,
  parameter int ALT_K   = 1,
  parameter int BIT_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              data_in,
  input  logic [7:0]        msg,
  output logic              bit_req,
  output logic signed [8:0] sample
);
  localparam int PA   = 8 * CAR_K;
  localparam int PB   = 8 * ALT_K;
  localparam int AW   = $clog2(PA);
  localparam int BW   = $clog2(PB);
  localparam int SYM2 = 2 * BIT_LEN;
  localparam int SW   = $clog2(SYM2);

  localparam logic [2:0] M_AM   = 3'd0;
  localparam logic [2:0] M_ASK  = 3'd1;
  localparam logic [2:0] M_BPSK = 3'd2;
  localparam logic [2:0] M_FSK  = 3'd3;
  localparam logic [2:0] M_QPSK = 3'd4;
  localparam logic [2:0] M_IDLE = 3'd7;

  localparam logic signed [8:0] AMP = 9'sd127;

  logic [AW-1:0] ca;
  logic [BW-1:0] cb;
  logic [SW-1:0] st;
  logic [2:0]    ld_mode, act_mode;
  logic          ld_b1, ld_b0, act_b1, act_b0, act_v;
  logic          sym_last, data_mode, pos_a, pos_b;
  logic [31:0]   off_a;
  logic signed [8:0] msg_s;

  function automatic logic pos_half(input logic [31:0] s, input logic [31:0] per);
    logic [31:0] w;
    w = (s >= per) ? s - per : s;
    return w < (per >> 1);
  endfunction

  assign sym_last  = (act_mode == M_QPSK) ? (st == SW'(SYM2 - 1)) : (st == SW'(BIT_LEN - 1));
  assign data_mode = (mode != M_AM) && (mode <= M_QPSK);
  assign bit_req   = rst_n && (((st == '0) && data_mode) ||
                               ((st == SW'(1)) && (ld_mode == M_QPSK)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca       <= '0;
      cb       <= '0;
      st       <= '0;
      ld_mode  <= M_IDLE;
      ld_b1    <= 1'b0;
      ld_b0    <= 1'b0;
      act_mode <= M_IDLE;
      act_b1   <= 1'b0;
      act_b0   <= 1'b0;
      act_v    <= 1'b0;
    end else begin
      ca <= (ca == AW'(PA - 1)) ? '0 : ca + 1'b1;
      cb <= (cb == BW'(PB - 1)) ? '0 : cb + 1'b1;
      st <= sym_last ? '0 : st + 1'b1;
      if (st == '0) begin
        ld_mode <= mode;
        ld_b1   <= data_in;
      end
      if ((st == SW'(1)) && (ld_mode == M_QPSK))
        ld_b0 <= data_in;
      if (sym_last) begin
        act_mode <= ld_mode;
        act_b1   <= ld_b1;
        act_b0   <= ld_b0;
        act_v    <= 1'b1;
      end
    end
  end

  always_comb begin
    off_a = '0;
    if (act_mode == M_BPSK && !act_b1)
      off_a = 32'(4 * CAR_K);
    else if (act_mode == M_QPSK) begin
      case ({act_b1, act_b0})
        2'b00:   off_a = 32'(CAR_K);
        2'b01:   off_a = 32'(3 * CAR_K);
        2'b11:   off_a = 32'(5 * CAR_K);
        default: off_a = 32'(7 * CAR_K);
      endcase
    end
  end

  assign pos_a = pos_half(32'(ca) + off_a, 32'(PA));
  assign pos_b = pos_half(32'(cb), 32'(PB));
  assign msg_s = $signed({1'b0, msg});

  always_comb begin
    sample = '0;
    if (act_v) begin
      case (act_mode)
        M_AM:   sample = pos_a ? msg_s : -msg_s;
        M_ASK:  sample = act_b1 ? (pos_a ? AMP : -AMP) : '0;
        M_BPSK: sample = pos_a ? AMP : -AMP;
        M_FSK:  sample = (act_b1 ? pos_a : pos_b) ? AMP : -AMP;
        M_QPSK: sample = pos_a ? AMP : -AMP;
        default: sample = '0;
      endcase
    end
  end
endmodule

// File: rtl/sqcar_mod_chk.sv
module sqcar_mod_chk #(
  parameter int BIT_LEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              bit_req,
  input logic signed [8:0] sample,
  input logic [$clog2(2*BIT_LEN)-1:0] st,
  input logic [2:0]        act_mode,
  input logic [2:0]        ld_mode,
  input logic              act_v
);
  localparam int SW = $clog2(2 * BIT_LEN);

  logic [SW:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age < (SW+1)'(BIT_LEN)) age <= age + 1'b1;
  end

  p_start_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age < (SW+1)'(BIT_LEN)) |-> (sample == 9'sd0));

  p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == '0) && (mode > 3'd4)) |-> !bit_req);

  p_keyed_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && (act_mode != 3'd0)) |->
      ((sample == 9'sd0) || (sample == 9'sd127) || (sample == -9'sd127)));

  p_req_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> (!bit_req || (ld_mode == 3'd4)));

  p_req_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && (st != '0)) |=> !bit_req);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != '0) |-> $stable(act_mode));
endmodule

bind sqcar_mod sqcar_mod_chk #(.BIT_LEN(BIT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bit_req(bit_req), .sample(sample),
  .st(st), .act_mode(act_mode), .ld_mode(ld_mode), .act_v(act_v)
);

// File: tb/sqcar_mod_bench.sv
module sqcar_mod_bench;
  localparam int CLK_P = 10;
  localparam int CK    = 2;
  localparam int AK    = 1;
  localparam int BL    = 32;
  localparam int PA    = 8 * CK;
  localparam int PB    = 8 * AK;
  localparam int NV    = 13;

  // {mode[15:13], late mode[12:10], b1[9], b0[8], msg[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 3'd4, 1'b1, 1'b0, 8'd200},
    {3'd1, 3'd0, 1'b1, 1'b0, 8'd0},
    {3'd1, 3'd2, 1'b0, 1'b1, 8'd0},
    {3'd2, 3'd1, 1'b1, 1'b0, 8'd0},
    {3'd2, 3'd4, 1'b0, 1'b0, 8'd0},
    {3'd3, 3'd0, 1'b1, 1'b0, 8'd0},
    {3'd3, 3'd1, 1'b0, 1'b0, 8'd0},
    {3'd4, 3'd2, 1'b0, 1'b0, 8'd0},
    {3'd4, 3'd3, 1'b0, 1'b1, 8'd0},
    {3'd4, 3'd0, 1'b1, 1'b1, 8'd0},
    {3'd4, 3'd1, 1'b1, 1'b0, 8'd0},
    {3'd6, 3'd4, 1'b1, 1'b1, 8'd0},
    {3'd0, 3'd2, 1'b0, 1'b1, 8'd5}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode = 3'd7;
  logic              data_in = 1'b0;
  logic [7:0]        msg = 8'd0;
  logic              bit_req;
  logic signed [8:0] sample;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 1'b0;

  sqcar_mod #(.CAR_K(CK), .ALT_K(AK), .BIT_LEN(BL)) u_sqcar_mod (
    .clk(clk), .rst_n(rst_n), .mode(mode), .data_in(data_in), .msg(msg),
    .bit_req(bit_req), .sample(sample)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at t=%0d", tag, act, expv, t);
    end
  endtask

  function automatic bit ref_pos(input int tt, input int off);
    return ((tt + off) % PA) < (PA / 2);
  endfunction

  function automatic int expect_val(input logic [2:0] m, input logic b1, input logic b0,
                                    input int mv, input int tt);
    case (m)
      3'd0: return ref_pos(tt, 0) ? mv : -mv;
      3'd1: return b1 ? (ref_pos(tt, 0) ? 127 : -127) : 0;
      3'd2: return ref_pos(tt, b1 ? 0 : 4 * CK) ? 127 : -127;
      3'd3: return (b1 ? ref_pos(tt, 0) : ((tt % PB) < (PB / 2))) ? 127 : -127;
      3'd4: begin
        int off;
        case ({b1, b0})
          2'b00:   off = CK;
          2'b01:   off = 3 * CK;
          2'b11:   off = 5 * CK;
          default: off = 7 * CK;
        endcase
        return ref_pos(tt, off) ? 127 : -127;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R7 R10";
      3'd1: return "R3 R2 R10";
      3'd2: return "R4 R2 R10";
      3'd3: return "R5 R2 R10";
      3'd4: return "R6 R8 R10";
      default: return "R1 R10";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode  = 3'd4;
    #1;
    chk("R11 reset sample", int'(sample), 0);
    chk("R11 reset bit_req", int'(bit_req), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
  endtask

  task automatic run_table();
    for (int p = 0; p <= NV; p++) begin
      logic [2:0] nm, lm, dm;
      logic nb1, nb0, db1, db0;
      int dmsg, len;
      nm  = (p < NV) ? VEC[p][15:13] : 3'd7;
      lm  = (p < NV) ? VEC[p][12:10] : 3'd7;
      nb1 = (p < NV) ? VEC[p][9] : 1'b0;
      nb0 = (p < NV) ? VEC[p][8] : 1'b0;
      dm  = (p > 0) ? VEC[p-1][15:13] : 3'd7;
      db1 = (p > 0) ? VEC[p-1][9] : 1'b0;
      db0 = (p > 0) ? VEC[p-1][8] : 1'b0;
      dmsg = (p > 0) ? int'(VEC[p-1][7:0]) : 0;
      len = (dm == 3'd4) ? 2 * BL : BL;
      for (int c = 0; c < len; c++) begin
        int ereq;
        if (c == 0) begin
          mode = nm; data_in = nb1; msg = 8'(dmsg);
        end else if (c == 1) begin
          data_in = nb0;
        end else if (c == 2) begin
          data_in = ~nb0;
          mode = lm;
        end
        #1;
        if (c == 0) ereq = (nm >= 3'd1 && nm <= 3'd4) ? 1 : 0;
        else if (c == 1) ereq = (nm == 3'd4) ? 1 : 0;
        else ereq = 0;
        chk("R9 R8 bit_req", int'(bit_req), ereq);
        if (p == 0) chk("R11 start zero", int'(sample), 0);
        else chk(tag_of(dm), int'(sample), expect_val(dm, db1, db0, dmsg, t));
        @(posedge clk);
        t++;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #1;
    chk("R11 reset sample", int'(sample), 0);
    chk("R11 reset bit_req", int'(bit_req), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    run_table();
    // reset in mid-symbol, then the whole sequence again
    repeat (7) begin
      @(posedge clk);
      t++;
    end
    do_reset();
    run_table();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule